// File: doc/BRIEF.md
# SDRAM Command and Refresh Controller

This block sits between a host that issues single-word read and write requests and a four-bank, 16-bit synchronous DRAM. It turns each request into a row activation followed, after the row-to-column delay, by a column read or write that closes the row by itself through auto precharge. Each access is a closed-page access, and only one row is open at any time.

The controller also runs the power-up sequence and sends periodic auto refresh commands. All row timings are given in picoseconds and converted to clock cycles at elaboration. The host sees a ready/valid handshake. Read data comes back as a one-cycle response pulse, at a fixed distance after the read command that the programmed CAS latency sets.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset the bus carries NOP and `req_ready` stays low. After PWRUP_CYC+1 clock edges the controller issues PRECHARGE with A10 high (all banks). RP cycles later it issues REFRESH, RC cycles after that a second REFRESH, and RC cycles after that MODE SET with A[6:4] = CAS latency and all other address bits and BA zero (burst length 1, sequential).
- R2: Commands are driven as {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE SET 0000.
- R3: A request accepted at a clock edge (`req_valid` and `req_ready` both high) puts ACTIVE on the bus after that edge, with BA = bank and A = row.
- R4: READ or WRITE follows ACTIVE exactly RCD cycles later, with A10 high (auto precharge), A[7:0] = column, the other A bits zero and the same BA.
- R5: After an ACTIVE, no ACTIVE or REFRESH is issued for CLOSE = max(RC, RAS+RP) cycles. After a REFRESH, none is issued for RC cycles.
- R6: Cycle counts round the picosecond timings up at the clock period. At 7500 ps: RCD = 3, RAS = 6, RC = 9, RP = 3, so CLOSE = 9.
- R7: Once MODE SET has been issued, a refresh becomes pending every REF_CYC cycles. When the controller is idle and its timing window has expired, a pending refresh is issued before any waiting host request.
- R8: `req_ready` is high only when initialisation is done, the controller is idle, its timing window has expired and no refresh is pending. A request that is not accepted stays pending, with no effect on the bus.
- R9: For a READ issued at edge e, `rsp_valid` pulses for one cycle after edge e+1+CAS_LAT, and `rsp_rdata` then holds the value that `sd_dq_in` had at that edge.
- R10: `sd_dq_oe` is high only in the cycle where WRITE is on the bus, and `sd_dq_out` then carries the request's write data.
- R11: The host address is split as {bank[1:0], row[11:0], column[7:0]}, most significant field first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Row / column / mode address |
| sd_dq_out | output | 16 | Data toward the memory |
| sd_dq_oe | output | 1 | Drive enable for `sd_dq_out` |
| sd_dq_in | input | 16 | Data from the memory |

## Verification
A refresh coming due and a host request waiting at the idle state can meet in the same cycle. The bench sets a short refresh interval and keeps requests queued back to back with irregular gaps, so the pending refresh repeatedly falls on a cycle where the timing window expires with `req_valid` already high. A cycle-accurate model in the bench predicts that REFRESH goes out first, that `req_ready` stays low during it, and that the held request gets its ACTIVE RC cycles later. The bus and the handshake are compared on every clock.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_RD  = 4'b0101,
      CMD_NOP = 4'b0111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_PALL,
      ST_REF1,
      ST_REF2,
      ST_MRS,
      ST_IDLE,
      ST_RW
   } ctl_st_e;

   function automatic int ps_to_cyc(input int ps, input int clk_ps);
      return (ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
   parameter int W       = 8,
   parameter int RST_VAL = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   if (RST_VAL >= (1 << W)) begin : g_bad_rst
      $error("sdram_gap_timer: RST_VAL does not fit W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= W'(RST_VAL);
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
   parameter int REF_CYC = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ack,
   output logic pend
);
   localparam int CW = (REF_CYC > 2) ? $clog2(REF_CYC) : 1;

   logic [CW-1:0] cnt;
   logic          hit;

   if (REF_CYC < 2) begin : g_bad_ref
      $error("sdram_refresh_timer: REF_CYC must be at least 2");
   end

   assign hit = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= CW'(REF_CYC - 1);
         pend <= 1'b0;
      end else begin
         if (run) cnt <= hit ? CW'(REF_CYC - 1) : cnt - 1'b1;
         if (hit)      pend <= 1'b1;
         else if (ack) pend <= 1'b0;
      end
   end

   // R7: a new interval never ends while the previous one is still unserved
   p_no_lost_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (!pend || ack));

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
   parameter int CAS_LAT = 3,
   parameter int DW      = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_issue,
   input  logic [DW-1:0] dq_in,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data
);
   logic pipe [0:CAS_LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= 1'b0;
      else        pipe[0] <= rd_issue;
   end

   for (genvar i = 1; i <= CAS_LAT; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[i] <= 1'b0;
         else        pipe[i] <= pipe[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= pipe[CAS_LAT];
         if (pipe[CAS_LAT]) rsp_data <= dq_in;
      end
   end

   // R9: closed-page accesses never return two words back to back
   p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
   import sdram_ctrl_pkg::*;
#(
   parameter int DW        = 16,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 8,
   parameter int CLK_PS    = 7500,
   parameter int T_RCD_PS  = 20000,
   parameter int T_RAS_PS  = 45000,
   parameter int T_RC_PS   = 67500,
   parameter int T_RP_PS   = 20000,
   parameter int T_MRD_CYC = 2,
   parameter int CAS_LAT   = 3,
   parameter int PWRUP_CYC = 13334,
   parameter int REF_CYC   = 1024
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic                            req_write,
   input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
   input  logic [DW-1:0]                   req_wdata,
   output logic                            rsp_valid,
   output logic [DW-1:0]                   rsp_rdata,
   output logic                            sd_cs_n,
   output logic                            sd_ras_n,
   output logic                            sd_cas_n,
   output logic                            sd_we_n,
   output logic [BANK_W-1:0]               sd_ba,
   output logic [ROW_W-1:0]                sd_addr,
   output logic [DW-1:0]                   sd_dq_out,
   output logic                            sd_dq_oe,
   input  logic [DW-1:0]                   sd_dq_in
);
   localparam int ADDR_W    = BANK_W + ROW_W + COL_W;
   localparam int RCD_CYC   = ps_to_cyc(T_RCD_PS, CLK_PS);
   localparam int RAS_CYC   = ps_to_cyc(T_RAS_PS, CLK_PS);
   localparam int RC_CYC    = ps_to_cyc(T_RC_PS, CLK_PS);
   localparam int RP_CYC    = ps_to_cyc(T_RP_PS, CLK_PS);
   localparam int CLOSE_CYC = max_int(RC_CYC, RAS_CYC + RP_CYC);
   localparam int MAX_WAIT  = max_int(PWRUP_CYC, CLOSE_CYC);
   localparam int TMR_W     = $clog2(MAX_WAIT + 1);
   localparam int SW        = $clog2(CLOSE_CYC + 2);
   localparam int A10       = 10;

   // ---------------- elaboration checks ----------------
   if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cl
      $error("sdram_cmd_ctrl: CAS_LAT must be 2 or 3");
   end
   if (COL_W > A10 || ROW_W <= A10) begin : g_bad_addr
      $error("sdram_cmd_ctrl: column must sit below A10 and row must include it");
   end
   if (RCD_CYC < 1 || CLOSE_CYC <= RCD_CYC || T_MRD_CYC < 1) begin : g_bad_timing
      $error("sdram_cmd_ctrl: inconsistent row timings");
   end
   if (BANK_W < 1 || DW < 1) begin : g_bad_width
      $error("sdram_cmd_ctrl: bad widths");
   end

   // ---------------- state ----------------
   ctl_st_e             st_q, st_nx;
   sd_cmd_e             cmd_q, cmd_nx;
   logic [BANK_W-1:0]   ba_q, ba_nx;
   logic [ROW_W-1:0]    a_q, a_nx;
   logic [DW-1:0]       dq_q, dq_nx;
   logic                oe_q, oe_nx;
   logic                done_q, done_set;
   logic                tmr_load, tmr_zero;
   logic [TMR_W-1:0]    tmr_val;
   logic                ref_pend, ref_ack;
   logic                rd_issue, accept;

   logic [BANK_W-1:0]   r_bank_q;
   logic [COL_W-1:0]    r_col_q;
   logic                r_wr_q;
   logic [DW-1:0]       r_wdata_q;

   wire [BANK_W-1:0] in_bank = req_addr[ADDR_W-1 -: BANK_W];
   wire [ROW_W-1:0]  in_row  = req_addr[COL_W +: ROW_W];
   wire [COL_W-1:0]  in_col  = req_addr[COL_W-1:0];

   // ---------------- sub-blocks ----------------
   sdram_gap_timer #(.W(TMR_W), .RST_VAL(PWRUP_CYC)) i_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sdram_refresh_timer #(.REF_CYC(REF_CYC)) i_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (done_q),
      .ack   (ref_ack),
      .pend  (ref_pend)
   );

   sdram_rd_capture #(.CAS_LAT(CAS_LAT), .DW(DW)) i_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_issue  (rd_issue),
      .dq_in     (sd_dq_in),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_rdata)
   );

   assign req_ready = done_q && (st_q == ST_IDLE) && tmr_zero && !ref_pend;
   assign accept    = req_ready && req_valid;

   // ---------------- command sequencing ----------------
   always_comb begin
      st_nx    = st_q;
      cmd_nx   = CMD_NOP;
      ba_nx    = '0;
      a_nx     = '0;
      dq_nx    = '0;
      oe_nx    = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      ref_ack  = 1'b0;
      rd_issue = 1'b0;
      done_set = 1'b0;
      if (tmr_zero) begin
         unique case (st_q)
            ST_PALL: begin
               cmd_nx    = CMD_PRE;
               a_nx[A10] = 1'b1;
               st_nx     = ST_REF1;
               tmr_load  = 1'b1;
               tmr_val   = TMR_W'(RP_CYC - 1);
            end
            ST_REF1: begin
               cmd_nx   = CMD_REF;
               st_nx    = ST_REF2;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(RC_CYC - 1);
            end
            ST_REF2: begin
               cmd_nx   = CMD_REF;
               st_nx    = ST_MRS;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(RC_CYC - 1);
            end
            ST_MRS: begin
               cmd_nx    = CMD_MRS;
               a_nx[6:4] = 3'(CAS_LAT);
               st_nx     = ST_IDLE;
               tmr_load  = 1'b1;
               tmr_val   = TMR_W'(T_MRD_CYC - 1);
               done_set  = 1'b1;
            end
            ST_IDLE: begin
               if (ref_pend) begin
                  cmd_nx   = CMD_REF;
                  ref_ack  = 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(RC_CYC - 1);
               end else if (accept) begin
                  cmd_nx   = CMD_ACT;
                  ba_nx    = in_bank;
                  a_nx     = in_row;
                  st_nx    = ST_RW;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(RCD_CYC - 1);
               end
            end
            ST_RW: begin
               cmd_nx               = r_wr_q ? CMD_WR : CMD_RD;
               ba_nx                = r_bank_q;
               a_nx[COL_W-1:0]      = r_col_q;
               a_nx[A10]            = 1'b1;
               oe_nx                = r_wr_q;
               dq_nx                = r_wr_q ? r_wdata_q : '0;
               rd_issue             = !r_wr_q;
               st_nx                = ST_IDLE;
               tmr_load             = 1'b1;
               tmr_val              = TMR_W'(CLOSE_CYC - RCD_CYC - 1);
            end
            default: st_nx = ST_PALL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_PALL;
         cmd_q     <= CMD_NOP;
         ba_q      <= '0;
         a_q       <= '0;
         dq_q      <= '0;
         oe_q      <= 1'b0;
         done_q    <= 1'b0;
         r_bank_q  <= '0;
         r_col_q   <= '0;
         r_wr_q    <= 1'b0;
         r_wdata_q <= '0;
      end else begin
         st_q  <= st_nx;
         cmd_q <= cmd_nx;
         ba_q  <= ba_nx;
         a_q   <= a_nx;
         dq_q  <= dq_nx;
         oe_q  <= oe_nx;
         if (done_set) done_q <= 1'b1;
         if (accept) begin
            r_bank_q  <= in_bank;
            r_col_q   <= in_col;
            r_wr_q    <= req_write;
            r_wdata_q <= req_wdata;
         end
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_ba     = ba_q;
   assign sd_addr   = a_q;
   assign sd_dq_out = dq_q;
   assign sd_dq_oe  = oe_q;

   // ---------------- assertions ----------------
   logic [SW-1:0] since_act, since_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_act <= SW'(CLOSE_CYC + 1);
         since_row <= SW'(CLOSE_CYC + 1);
      end else begin
         if (cmd_q == CMD_ACT)                     since_act <= SW'(1);
         else if (since_act != SW'(CLOSE_CYC + 1)) since_act <= since_act + 1'b1;
         if (cmd_q == CMD_ACT || cmd_q == CMD_REF) since_row <= SW'(1);
         else if (since_row != SW'(CLOSE_CYC + 1)) since_row <= since_row + 1'b1;
      end
   end

   p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (since_act == SW'(RCD_CYC)));

   p_auto_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_addr[A10]);

   p_row_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT || cmd_q == CMD_REF) |-> (since_row >= SW'(RC_CYC)));

   p_ref_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pend && st_q == ST_IDLE && tmr_zero) |=> (cmd_q == CMD_REF));

   p_oe_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sd_dq_oe |-> (cmd_q == CMD_WR));

   p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> (cmd_q != CMD_ACT && cmd_q != CMD_RD && cmd_q != CMD_WR));

endmodule

// File: tb/test_sdram_cmd_ctrl.sv
module test_sdram_cmd_ctrl;

   localparam int PWRUP = 16;
   localparam int REFI  = 60;
   localparam int CL    = 3;
   // R6: 20000/7500 -> 3, 45000/7500 -> 6, 67500/7500 -> 9, 20000/7500 -> 3
   localparam int RCD   = 3;
   localparam int RC    = 9;
   localparam int RP    = 3;
   localparam int CLOSE = 9;
   localparam int MRD   = 2;

   localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                          C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                          C_MRS = 4'b0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [21:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [11:0] sd_addr;
   logic [15:0] sd_dq_out;
   logic        sd_dq_oe;
   logic [15:0] sd_dq_in = 16'h5A5A;

   always #10 clk = ~clk;

   sdram_cmd_ctrl #(
      .CAS_LAT(CL), .PWRUP_CYC(PWRUP), .REF_CYC(REFI)
   ) i_sdram_cmd_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_addr(sd_addr),
      .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   function automatic void chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endfunction

   // ---------------- behavioural reference model ----------------
   int          n = 0;
   int          step = 0;
   int          next_free = PWRUP + 1;
   int          phase = 0;
   bit          pend = 0;
   bit          done = 0;
   int          ref_next = 0;
   int          act_edge = 0;
   bit          m_wr;
   logic [1:0]  m_bank;
   logic [11:0] m_row;
   logic [7:0]  m_col;
   logic [15:0] m_data;
   logic [3:0]  e_cmd = C_NOP;
   logic [1:0]  e_ba = '0;
   logic [11:0] e_addr = '0;
   logic [15:0] e_dq = '0;
   string       e_tag = "R2";
   int          rsp_due = -1;
   logic [15:0] rsp_exp = '0;
   logic [15:0] shadow [int];

   always @(posedge clk) begin
      if (!rst_n) begin
         n = 0;
      end else begin
         n++;
         e_cmd = C_NOP; e_ba = '0; e_addr = '0; e_dq = '0; e_tag = "R2";
         if (step < 4) begin
            if (n >= next_free) begin
               e_tag = "R1";
               case (step)
                  0: begin e_cmd = C_PRE; e_addr = 12'h400; next_free = n + RP; end
                  1, 2: begin e_cmd = C_REF; next_free = n + RC; end
                  default: begin
                     e_cmd = C_MRS; e_addr = 12'(CL << 4); next_free = n + MRD;
                     done = 1; ref_next = n + REFI;
                  end
               endcase
               step++;
            end
         end else begin
            if (phase == 0 && n >= next_free) begin
               if (pend) begin
                  e_cmd = C_REF; e_tag = "R7"; pend = 0; next_free = n + RC;
               end else if (req_valid) begin
                  m_wr = req_write; m_bank = req_addr[21:20];
                  m_row = req_addr[19:8]; m_col = req_addr[7:0]; m_data = req_wdata;
                  e_cmd = C_ACT; e_tag = "R3"; e_ba = m_bank; e_addr = m_row;
                  phase = 1; act_edge = n; next_free = n + RCD;
                  if (m_wr) shadow[int'(req_addr)] = m_data;
               end
            end else if (phase == 1 && n >= next_free) begin
               e_tag = "R4"; e_ba = m_bank; e_addr = {4'b0100, m_col};
               if (m_wr) begin
                  e_cmd = C_WR; e_dq = m_data;
               end else begin
                  e_cmd = C_RD; rsp_due = n + 1 + CL;
                  rsp_exp = shadow.exists(int'({m_bank, m_row, m_col})) ?
                            shadow[int'({m_bank, m_row, m_col})] : ~m_col ^ {4'h0, m_row};
               end
               phase = 0; next_free = act_edge + CLOSE;
            end
            if (done && n == ref_next) begin
               pend = 1; ref_next += REFI;
            end
         end
      end
   end

   // ---------------- memory device model ----------------
   logic [11:0] open_row [4];
   logic [15:0] dev_mem [int];
   int          dq_due [$];
   logic [15:0] dq_val [$];
   int          last_act = -100;
   int          last_row_evt = -100;

   always @(negedge clk) begin
      logic [3:0] cmd;
      int key;
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      sd_dq_in <= 16'h5A5A;
      if (dq_due.size() > 0 && dq_due[0] == n) begin
         sd_dq_in <= dq_val[0];
         void'(dq_due.pop_front());
         void'(dq_val.pop_front());
      end
      if (rst_n) begin
         key = int'({sd_ba, open_row[sd_ba], sd_addr[7:0]});
         if (cmd == C_ACT) open_row[sd_ba] = sd_addr;
         if (cmd == C_WR) dev_mem[key] = sd_dq_out;
         if (cmd == C_RD) begin
            dq_due.push_back(n + CL);
            dq_val.push_back(dev_mem.exists(key) ? dev_mem[key]
                             : ~sd_addr[7:0] ^ {4'h0, open_row[sd_ba]});
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      logic [3:0] cmd;
      bit m_ready;
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (!rst_n) begin
         chk(cmd == C_NOP, "R1 reset cmd", cmd, C_NOP);
         chk(!req_ready, "R1 reset ready", req_ready, 0);
         chk(!rsp_valid, "R9 reset rsp", rsp_valid, 0);
      end else if (!finished) begin
         chk(cmd == e_cmd, e_tag, cmd, e_cmd);
         if (e_cmd != C_NOP) begin
            chk(sd_ba == e_ba, (e_cmd == C_ACT) ? "R11 bank" : e_tag, sd_ba, e_ba);
            chk(sd_addr == e_addr, (e_cmd == C_ACT) ? "R11 row" : e_tag, sd_addr, e_addr);
         end
         chk(sd_dq_oe == (e_cmd == C_WR), "R10 oe", sd_dq_oe, e_cmd == C_WR);
         if (e_cmd == C_WR) chk(sd_dq_out == e_dq, "R10 data", sd_dq_out, e_dq);
         m_ready = done && phase == 0 && (n + 1) >= next_free && !pend;
         chk(req_ready == m_ready, "R8 ready", req_ready, m_ready);
         chk(rsp_valid == (n == rsp_due), "R9 valid", rsp_valid, n == rsp_due);
         if (n == rsp_due) chk(rsp_rdata == rsp_exp, "R9 data", rsp_rdata, rsp_exp);
         if (cmd == C_RD || cmd == C_WR)
            chk(n - last_act == 3, "R6 rcd", n - last_act, 3);
         if (cmd == C_ACT || cmd == C_REF) begin
            chk(n - last_row_evt >= 9, "R5 row gap", n - last_row_evt, 9);
            last_row_evt = n;
         end
         if (cmd == C_ACT) last_act = n;
      end
   end

   // ---------------- stimulus ----------------
   task automatic send(input bit w, input logic [21:0] a, input logic [15:0] d);
      req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   logic [21:0] addrs [8];

   initial begin
      logic [15:0] lfsr;
      addrs[0] = 22'h000000; addrs[1] = 22'h3FFFFF; addrs[2] = 22'h112345;
      addrs[3] = 22'h2ABC12; addrs[4] = 22'h0FFF00; addrs[5] = 22'h300FFF;
      addrs[6] = 22'h155555; addrs[7] = 22'h2AAAAA;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: request held during power-up must not be taken early
      send(1'b1, addrs[0], 16'h1234);
      for (int i = 1; i < 8; i++) send(1'b1, addrs[i], 16'hA000 + 16'(i));
      for (int i = 0; i < 8; i++) begin
         send(1'b0, addrs[i], 16'h0);
         repeat (i % 3) @(negedge clk);
      end
      lfsr = 16'hACE1;
      for (int i = 0; i < 160; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send(lfsr[0], addrs[lfsr[3:1]] ^ {14'h0, lfsr[11:4] & 8'h03}, lfsr);
         repeat (lfsr[7:6] == 2'b11 ? int'(lfsr[10:8]) : 0) @(negedge clk);
      end
      repeat (20) @(negedge clk);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule